// File: doc/BRIEF.md
# DAC Code Register with Load Control

This block holds the code that drives a single voltage-output DAC. Commands arrive already framed and decoded by a serial front end. Each command is one word with an 8-bit opcode in bits [23:16] and a 16-bit data field in bits [15:0]. A write command fills a holding (input) register. The code reaches the output register in one of two ways. The first is an active-low load pin, `ldac_n`. While the pin is low, the holding register is transparent and writes pass straight through to the output. The second is a software load command. It copies the holding register only when its flag bit is set.

A software clear puts the block back into its power-on state. The output code then depends on a mode pin: zero scale or midscale. A power-control command sets two stored bits. One asks for the output to be disconnected and grounded. The other enables the chain-ready output of the serial front end. While powered down, the block keeps its output code so that power-up restores it. Commands are still accepted in this state.

Top module: `dac_load_ctrl`

## Requirements
- R1: While `rst_n` is low, `dac_code` and the holding register take the reset code, `pwr_down` is 0 and `ready_en` is 1. The reset code is 0x0000 when `mode_mid`=0 and 0x8000 when `mode_mid`=1.
- R2: A write command (opcode 0x30) stores data[15:0] in the holding register. If `ldac_n` is high, `dac_code` does not change.
- R3: At any clock edge where `ldac_n` is low, `dac_code` takes the holding-register contents from the next cycle on.
- R4: A write command at an edge where `ldac_n` is low appears on `dac_code` in the next cycle.
- R5: A load command (opcode 0x01) with data bit 0 = 1 copies the holding register into `dac_code`.
- R6: A load command with data bit 0 = 0 leaves `dac_code` unchanged while `ldac_n` is high.
- R7: A clear command (opcode 0x02) sets the holding register and `dac_code` to the reset code chosen by `mode_mid` in that cycle, sets `pwr_down` to 0 and `ready_en` to 1. It wins over a low `ldac_n` in the same cycle.
- R8: A power command (opcode 0x03) sets `pwr_down` from data bit 0 and `ready_en` from data bit 1.
- R9: While `pwr_down` is 1, `dac_code` keeps its value. Write and load commands still take effect.
- R10: Any other opcode, or a cycle with `cmd_valid` low, changes no output while `ldac_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mid | input | 1 | Reset-code select: 0 zero scale, 1 midscale |
| ldac_n | input | 1 | Active-low load; level-sensitive transparency |
| cmd_valid | input | 1 | Command word valid this cycle |
| cmd_word | input | 24 | Opcode [23:16], data [15:0] |
| dac_code | output | 16 | Code applied to the converter |
| pwr_down | output | 1 | Output disconnected and grounded |
| ready_en | output | 1 | Chain-ready output enable |

## Verification
The pin load and the command path can act on the same edge. The cases that matter most are a write landing while `ldac_n` is low, and a clear or a flag-0 load arriving while the pin is low. The random stimulus holds `ldac_n` low in about a fifth of the cycles, independent of the command stream, so these pairs come up often. Directed steps also force each pairing once. A bench model applies the order stated in the requirements: clear first, then the pin, then the load command. Every cycle, the model's code and power bits are compared with the outputs.

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl #(
  parameter int CODE_W = 16,
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] OP_LOAD = 8'h01,
  parameter logic [OP_W-1:0] OP_CLEAR = 8'h02,
  parameter logic [OP_W-1:0] OP_POWER = 8'h03,
  parameter logic [OP_W-1:0] OP_WRITE = 8'h30
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_mid,
  input  logic                   ldac_n,
  input  logic                   cmd_valid,
  input  logic [OP_W+CODE_W-1:0] cmd_word,
  output logic [CODE_W-1:0]      dac_code,
  output logic                   pwr_down,
  output logic                   ready_en
);
  localparam int WORD_W = OP_W + CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [OP_W-1:0]   op;
  logic [CODE_W-1:0] data, in_reg, in_next, rst_code;
  logic is_wr, is_ld, is_clr, is_pw;

  assign op       = cmd_word[WORD_W-1:CODE_W];
  assign data     = cmd_word[CODE_W-1:0];
  assign is_wr    = cmd_valid && op == OP_WRITE;
  assign is_ld    = cmd_valid && op == OP_LOAD;
  assign is_clr   = cmd_valid && op == OP_CLEAR;
  assign is_pw    = cmd_valid && op == OP_POWER;
  assign rst_code = mode_mid ? MID_CODE : '0;
  assign in_next  = is_wr ? data : in_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reg   <= rst_code;
      dac_code <= rst_code;
      pwr_down <= 1'b0;
      ready_en <= 1'b1;
    end else if (is_clr) begin
      in_reg   <= rst_code;
      dac_code <= rst_code;
      pwr_down <= 1'b0;
      ready_en <= 1'b1;
    end else begin
      in_reg <= in_next;
      if (!ldac_n) dac_code <= in_next;
      else if (is_ld && data[0]) dac_code <= in_reg;
      if (is_pw) begin
        pwr_down <= data[0];
        ready_en <= data[1];
      end
    end
  end
endmodule

// File: rtl/dac_load_ctrl_chk.sv
module dac_load_ctrl_chk #(
  parameter int CODE_W = 16,
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] OP_LOAD = 8'h01,
  parameter logic [OP_W-1:0] OP_CLEAR = 8'h02,
  parameter logic [OP_W-1:0] OP_POWER = 8'h03,
  parameter logic [OP_W-1:0] OP_WRITE = 8'h30
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_mid,
  input logic                   ldac_n,
  input logic                   cmd_valid,
  input logic [OP_W+CODE_W-1:0] cmd_word,
  input logic [CODE_W-1:0]      dac_code,
  input logic                   pwr_down,
  input logic                   ready_en
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  logic [OP_W-1:0] op;
  logic known;
  assign op = cmd_word[OP_W+CODE_W-1:CODE_W];
  assign known = op == OP_LOAD || op == OP_CLEAR || op == OP_POWER || op == OP_WRITE;

  // R7
  clear_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_CLEAR) |=>
      (dac_code == ($past(mode_mid) ? MID_CODE : '0)) && !pwr_down && ready_en);
  // R4
  transparent_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_n && cmd_valid && op == OP_WRITE) |=> dac_code == $past(cmd_word[CODE_W-1:0]));
  // R2
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_n && cmd_valid && op == OP_WRITE) |=> $stable(dac_code));
  // R6
  flag_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_n && cmd_valid && op == OP_LOAD && !cmd_word[0]) |=> $stable(dac_code));
  // R8
  power_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_POWER) |=>
      (pwr_down == $past(cmd_word[0])) && (ready_en == $past(cmd_word[1])));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_n && (!cmd_valid || !known)) |=> $stable({dac_code, pwr_down, ready_en}));
endmodule

bind dac_load_ctrl dac_load_ctrl_chk #(
  .CODE_W(CODE_W), .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_CLEAR(OP_CLEAR),
  .OP_POWER(OP_POWER), .OP_WRITE(OP_WRITE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_mid(mode_mid), .ldac_n(ldac_n),
  .cmd_valid(cmd_valid), .cmd_word(cmd_word), .dac_code(dac_code),
  .pwr_down(pwr_down), .ready_en(ready_en)
);

// File: tb/sim_dac_load_ctrl.sv
`timescale 1ns/1ps
module sim_dac_load_ctrl;
  localparam logic [7:0] OP_LOAD = 8'h01, OP_CLEAR = 8'h02, OP_POWER = 8'h03, OP_WRITE = 8'h30;

  logic clk = 0, rst_n = 0, mode_mid = 0, ldac_n = 1, cmd_valid = 0;
  logic [23:0] cmd_word = '0;
  logic [15:0] dac_code;
  logic pwr_down, ready_en;

  int checks = 0, errors = 0;
  logic [15:0] m_in, m_dac;
  logic m_pd, m_re;

  dac_load_ctrl u0 (.clk(clk), .rst_n(rst_n), .mode_mid(mode_mid), .ldac_n(ldac_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .dac_code(dac_code),
    .pwr_down(pwr_down), .ready_en(ready_en));

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rcode(input logic mid);
    return mid ? 16'h8000 : 16'h0000;
  endfunction

  task automatic check(input string req);
    checks++;
    if ({dac_code, pwr_down, ready_en} !== {m_dac, m_pd, m_re}) begin
      errors++;
      $display("FAIL %s: got code=%h pd=%b re=%b expected code=%h pd=%b re=%b",
               req, dac_code, pwr_down, ready_en, m_dac, m_pd, m_re);
    end
  endtask

  task automatic do_reset(input logic mid, input string req);
    rst_n = 0; mode_mid = mid; cmd_valid = 0; ldac_n = 1;
    repeat (2) @(negedge clk);
    m_in = rcode(mid); m_dac = rcode(mid); m_pd = 0; m_re = 1;
    check(req);
    rst_n = 1;
    @(negedge clk);
    check(req);
  endtask

  task automatic cyc(input logic v, input logic [7:0] op, input logic [15:0] d,
                     input logic ld_n, input logic mid, input string req_in);
    logic [15:0] nin;
    string req;
    cmd_valid = v; cmd_word = {op, d}; ldac_n = ld_n; mode_mid = mid;
    req = req_in;
    if (req == "") begin
      if (v && op == OP_CLEAR) req = "R7";
      else if (!ld_n && v && op == OP_WRITE) req = "R4";
      else if (!ld_n) req = "R3";
      else if (m_pd && v && (op == OP_WRITE || op == OP_LOAD)) req = "R9";
      else if (v && op == OP_WRITE) req = "R2";
      else if (v && op == OP_LOAD) req = d[0] ? "R5" : "R6";
      else if (v && op == OP_POWER) req = "R8";
      else req = "R10";
    end
    @(posedge clk);
    if (v && op == OP_CLEAR) begin
      m_in = rcode(mid); m_dac = rcode(mid); m_pd = 0; m_re = 1;
    end else begin
      nin = (v && op == OP_WRITE) ? d : m_in;
      if (!ld_n) m_dac = nin;
      else if (v && op == OP_LOAD && d[0]) m_dac = m_in;
      m_in = nin;
      if (v && op == OP_POWER) begin m_pd = d[0]; m_re = d[1]; end
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd5813));
    @(negedge clk);
    do_reset(1'b0, "R1");
    cyc(1, OP_WRITE, 16'h1234, 1, 0, "R2");
    cyc(0, 8'h00, 16'h0000, 1, 0, "R10");
    cyc(1, OP_LOAD, 16'hFFFE, 1, 0, "R6");
    cyc(1, OP_LOAD, 16'h0001, 1, 0, "R5");
    cyc(1, OP_WRITE, 16'hABCD, 1, 0, "R2");
    cyc(0, 8'h00, 16'h0000, 0, 0, "R3");
    cyc(1, OP_WRITE, 16'h5A5A, 0, 0, "R4");
    cyc(1, OP_LOAD, 16'h0000, 0, 0, "R3");
    cyc(1, 8'h7F, 16'hFFFF, 1, 0, "R10");
    cyc(1, OP_POWER, 16'h0001, 1, 0, "R8");
    cyc(1, OP_WRITE, 16'h0F0F, 1, 0, "R9");
    cyc(1, OP_LOAD, 16'h0001, 1, 0, "R9");
    cyc(1, OP_POWER, 16'h0000, 1, 0, "R8");
    cyc(1, OP_CLEAR, 16'h0000, 0, 1, "R7");
    cyc(1, OP_POWER, 16'h0003, 1, 1, "R8");
    cyc(1, OP_CLEAR, 16'hFFFF, 1, 0, "R7");
    do_reset(1'b1, "R1");
    for (int i = 0; i < 2000; i++) begin
      int k;
      logic [15:0] d;
      k = $urandom % 10;
      d = 16'($urandom);
      case (k)
        0, 1, 2: op = OP_WRITE;
        3, 4:    op = OP_LOAD;
        5:       op = OP_POWER;
        6:       op = ($urandom % 4 == 0) ? OP_CLEAR : OP_WRITE;
        7:       begin op = 8'($urandom); if (op inside {OP_LOAD, OP_CLEAR, OP_POWER, OP_WRITE}) op = 8'hEE; end
        default: op = OP_LOAD;
      endcase
      cyc(k != 9, op, d, ($urandom % 5) != 0, $urandom % 2, "");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule